// File: doc/BRIEF.md
# Rotating-Priority Output Arbiter with Log-Depth Selection

This block decides which of `N_REQ` switch inputs may drive one output port. Each input raises a request bit and the block returns a one-hot grant to a single winner. The inputs form a ring. After every new grant, the input just past the winner in ring order gets first claim on the next decision, so no steady requester can be starved.

The choice is made by a parallel-prefix tree of depth log2(`N_REQ`). It works the way an adder's carry logic does. A requesting position kills the grant for every position above it, and a position with no request passes the grant on. Two such trees run side by side. One covers the positions at or above the pointer and the other covers the whole ring, and together they handle the wrap-around.

Requests are registered on entry and the grant is registered on exit. A grant then stays with its holder until the holder withdraws its request. The block is meant to sit beside a crossbar column, and the grant vector drives that column's select.

Top module: `rra_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set in every cycle.
- R2: `gnt_o[i]` is set only if `req_i[i]` was high at the clock edge two edges before the one that produced the grant.
- R3: From an idle state, a request sampled at clock edge t shows up as a grant after edge t+1. This is two cycles, well inside the limit of seven.
- R4: While no request is present, no grant is issued and the priority pointer does not move.
- R5: A new decision grants the first requesting index at or above the pointer, scanning upward and wrapping from index `N_REQ-1` to index 0.
- R6: The pointer changes only when a new grant is issued, and it becomes the winner's index plus one, modulo `N_REQ`.
- R7: While the holder's request stays high, the grant stays with the holder, whatever the other inputs do.
- R8: When the holder drops its request, the next decision follows with no idle grant cycle in between. The new grant appears two edges after the drop is sampled. If nothing else is requesting, the grant clears.
- R9: Reset clears the grant and sets the pointer to 0, so the first decision after reset favours index 0.
- R10: The ring size `N_REQ` is a parameter valid from 2 to 144. Sizes that are not a power of two wrap correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | N_REQ | One request bit per input port |
| gnt_o | output | N_REQ | One-hot grant, all zero when idle |

## Verification
The bench builds the arbiter with `N_REQ` = 5. This size is not a power of two, so the prefix tree has an uneven top level and the wrap from index 4 back to 0 is exercised. At this size every request pattern (32 of them) can be tried from every pointer position (5 of them). The bench steers the pointer to each position through the normal request interface, then compares the grant with a ring scan computed in the bench. It also probes the hold, hand-off, idle-pointer and reset cases directly.

// File: rtl/rra_pkg.sv
package rra_pkg;

  // Outcome of one arbitration cycle.
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,  // nothing requesting, grant cleared
    DEC_KEEP = 2'd1,  // current holder still requesting
    DEC_NEW  = 2'd2   // fresh winner chosen from the tree
  } rra_dec_e;

  localparam int unsigned RRA_MAX_REQ = 144;

endpackage

// File: rtl/rra_reset_sync.sv
module rra_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/rra_kill_tree.sv
// Log-depth prefix tree: killed_o[i] is high when any kill_i[j] with j < i
// is high, i.e. a lower-indexed requester has already taken the grant.
module rra_kill_tree #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] kill_i,
  output logic [WIDTH-1:0] killed_o
);

  localparam int unsigned LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [LEVELS:0][WIDTH-1:0] lvl;

  assign lvl[0] = kill_i;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned SPAN = 2 ** l;
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (b >= SPAN) begin : g_merge
        assign lvl[l+1][b] = lvl[l][b] | lvl[l][b-SPAN];
      end else begin : g_pass
        assign lvl[l+1][b] = lvl[l][b];
      end
    end
  end

  // Shift the inclusive prefix up by one to make it exclusive.
  assign killed_o = {lvl[LEVELS][WIDTH-2:0], 1'b0};

endmodule

// File: rtl/rra_rr_pick.sv
// Rotating-priority pick: the upper tree covers requests at or above the
// pointer, the full tree covers the wrapped case.
module rra_rr_pick #(
  parameter int unsigned N_REQ = 16,
  parameter int unsigned IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [N_REQ-1:0] prio_mask;
  logic [N_REQ-1:0] req_upper;
  logic [N_REQ-1:0] killed_upper;
  logic [N_REQ-1:0] killed_all;
  logic [N_REQ-1:0] gnt_upper;
  logic [N_REQ-1:0] gnt_wrap;
  logic             any_upper;

  for (genvar i = 0; i < N_REQ; i++) begin : g_mask
    assign prio_mask[i] = (IDX_W'(i) >= ptr_i);
  end

  assign req_upper = req_i & prio_mask;

  rra_kill_tree #(.WIDTH(N_REQ)) u_tree_upper (
    .kill_i   (req_upper),
    .killed_o (killed_upper)
  );

  rra_kill_tree #(.WIDTH(N_REQ)) u_tree_all (
    .kill_i   (req_i),
    .killed_o (killed_all)
  );

  assign gnt_upper = req_upper & ~killed_upper;
  assign gnt_wrap  = req_i & ~killed_all;
  assign any_upper = |req_upper;
  assign any_o     = |req_i;

  always_comb begin
    gnt_o = any_upper ? gnt_upper : gnt_wrap;
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt_o[i]) begin
        idx_o = idx_o | IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rra_arbiter.sv
module rra_arbiter
  import rra_pkg::*;
#(
  parameter int unsigned N_REQ = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o
);

  localparam int unsigned IDX_W = $clog2(N_REQ);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

  logic             rst_n_sync;
  logic [N_REQ-1:0] req_q;
  logic [N_REQ-1:0] gnt_q;
  logic [N_REQ-1:0] gnt_d;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic             gnt_en;
  logic             ptr_en;
  logic [N_REQ-1:0] pick_gnt;
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             holding;
  rra_dec_e         dec;

  rra_reset_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_sync)
  );

  rra_rr_pick #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_pick (
    .req_i (req_q),
    .ptr_i (ptr_q),
    .gnt_o (pick_gnt),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  // Next-state logic
  always_comb begin
    holding = |(gnt_q & req_q);
    if (holding) begin
      dec = DEC_KEEP;
    end else if (pick_any) begin
      dec = DEC_NEW;
    end else begin
      dec = DEC_IDLE;
    end

    gnt_en = (dec != DEC_KEEP);
    gnt_d  = (dec == DEC_NEW) ? pick_gnt : '0;
    ptr_en = (dec == DEC_NEW);
    ptr_d  = (pick_idx == LAST_IDX) ? '0 : pick_idx + IDX_W'(1);
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      req_q <= '0;
    end else begin
      req_q <= req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign gnt_o = gnt_q;

endmodule

// File: rtl/rra_arbiter_chk.sv
module rra_arbiter_chk #(
  parameter int unsigned N_REQ = 16,
  parameter int unsigned IDX_W = $clog2(N_REQ)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_i,
  input logic [N_REQ-1:0] gnt_o,
  input logic [IDX_W-1:0] ptr_q
);

  function automatic logic [IDX_W-1:0] after_holder(logic [N_REQ-1:0] g);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (g[i]) r = (i == N_REQ - 1) ? '0 : IDX_W'(i + 1);
    end
    return r;
  endfunction

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r2_grant_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~$past(req_i, 2)) == '0));

  a_r4_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_i, 2) == '0) |-> (gnt_o == '0 && $stable(ptr_q)));

  a_r6_ptr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |-> (ptr_q == after_holder(gnt_o)));

  a_r6_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q < IDX_W'(N_REQ - 1)) || (ptr_q == IDX_W'(N_REQ - 1)));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(gnt_o) & $past(req_i, 2))) |-> (gnt_o == $past(gnt_o)));

endmodule

bind rra_arbiter rra_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .gnt_o  (gnt_o),
  .ptr_q  (ptr_q)
);

// File: tb/test_rra_arbiter.sv
`timescale 1ns/1ps
module test_rra_arbiter;

  localparam int N = 5;

  logic         clk;
  logic         rst_ni;
  logic [N-1:0] req;
  logic [N-1:0] gnt;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  rra_arbiter #(.N_REQ(N)) i_rra_arbiter (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .req_i  (req),
    .gnt_o  (gnt)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1;
      failures = failures + 1;
      $display("FAIL watchdog: got %0d cycles expected < 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] onehot(int i);
    return N'(1) << i;
  endfunction

  // Ring scan from pointer p upward, wrapping.
  function automatic logic [N-1:0] ring_pick(logic [N-1:0] pat, int p);
    for (int k = 0; k < N; k++) begin
      if (pat[(p + k) % N]) return onehot((p + k) % N);
    end
    return '0;
  endfunction

  initial begin
    rst_ni = 0;
    req    = '0;
    step(4);
    rst_ni = 1;
    step(4);
    chk("R9 reset grant", gnt, '0);

    // R3 latency and R9 pointer 0 after reset
    req = '1;
    step(1);
    chk("R3 not before two edges", gnt, '0);
    step(1);
    chk("R9 first winner index 0", gnt, onehot(0));

    // R7 hold while the holder keeps requesting
    for (int c = 0; c < 5; c++) begin
      step(1);
      chk("R7 hold under full load", gnt, onehot(0));
    end
    req = 5'b00001;
    step(3);
    chk("R7 hold with others gone", gnt, onehot(0));

    // R8 hand-off with no idle cycle
    req = 5'b11110;
    step(1);
    chk("R8 old holder still for one cycle", gnt, onehot(0));
    step(1);
    chk("R8 hand-off to next", gnt, onehot(1));

    // R8 clear, R4 idle keeps pointer at 2
    req = '0;
    step(2);
    chk("R8 clear when nobody left", gnt, '0);
    step(6);
    chk("R4 no grant while idle", gnt, '0);
    req = '1;
    step(2);
    chk("R4 pointer unchanged over idle", gnt, onehot(2));
    req = '0;
    step(2);

    // R5/R6/R10 sweep: every pointer, every pattern
    for (int p = 0; p < N; p++) begin
      for (int pat = 0; pat < (1 << N); pat++) begin
        req = onehot((p + N - 1) % N);
        step(2);
        chk("R6 setup single requester", gnt, onehot((p + N - 1) % N));
        req = '0;
        step(2);
        req = N'(pat);
        step(2);
        chk("R5 R10 ring pick", gnt, ring_pick(N'(pat), p));
        if (pat == 0) begin
          req = '1;
          step(2);
          chk("R4 R6 pointer kept after empty", gnt, onehot(p));
        end
        req = '0;
        step(2);
      end
    end

    // R6 pointer after wrap winner index 4 goes to 0
    req = 5'b10000;
    step(2);
    req = '0;
    step(2);
    req = 5'b10001;
    step(2);
    chk("R6 pointer wraps to 0", gnt, onehot(0));
    req = '0;
    step(2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule